// File: doc/BRIEF.md
# Ring-Buffer Remote DMA Data Port

This block lets a host move data in and out of a network controller's local buffer memory through one data port. The host first programs a ring: a start boundary, a stop boundary, a current remote address and a byte count. Each data-port access then moves data between the host and the buffer RAM at the current address. After the access, the block advances the address by the access size and lowers the remaining count. When the advanced address lands exactly on the stop boundary, it returns to the start boundary, so the buffer area behaves as a ring.

Accesses come in three sizes: byte, halfword and word. A configuration bit chooses byte or halfword for the narrow port. The word port always moves four bytes. The final access brings the count to zero, even if fewer bytes remained than the access moves. At that point the block sets a sticky completion status bit. The interrupt line is high while any enabled status bit is set. Write accesses made while the count is zero are dropped.

The buffer is a 16 KB byte-addressable RAM with one clock of read latency. Multi-byte accesses are assembled little-endian and need not be aligned.

Top module: `rdma_ring_port`

## Requirements
- R1: An accepted access adds its size to the remote address. The size is 4 when `dp_wide` is 1. Otherwise it is 2 when bit 0 of the configuration register is 1, and 1 when that bit is 0.
- R2: When the advanced address equals the stop register, the address is loaded from the start register instead.
- R3: The wrap uses equality only. An address that steps over the stop value without matching it keeps counting and does not wrap.
- R4: If the count is less than or equal to the access size, it becomes 0. Otherwise the access size is subtracted from it.
- R5: When an accepted access leaves the count at 0, status bit 0 (completion) is set. It stays set until the host writes 1 to bit 0 of the status register. Writing 0 there leaves it unchanged.
- R6: `irq` equals the OR of status AND mask, bit by bit. It is updated on the same edge as the status and mask registers.
- R7: A data-port write while the count is 0 changes nothing: no RAM byte, no address, no count and no status.
- R8: A data-port read is always accepted. `dp_rvalid` and `dp_rdata` are valid on the cycle after the request, and the read updates address, count and status exactly as a write does.
- R9: Write data is stored little-endian. Byte `k` of `dp_wdata[8k+7:8k]` goes to RAM address (address + k) modulo 16384, for `k` below the access size. Reads assemble bytes the same way.
- R10: The register map is selected by `reg_sel`: 0 start, 1 stop, 2 address, 3 count, 4 configuration (bit 0), 5 status (write-1-to-clear), 6 mask. `reg_rdata` shows the selected register one cycle after `reg_sel` is applied. Reset clears every register and `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Registered read data of the selected register |
| dp_req | input | 1 | Data-port access request, one cycle per access |
| dp_we | input | 1 | 1 = write access, 0 = read access |
| dp_wide | input | 1 | 1 = four-byte port, 0 = byte or halfword port |
| dp_wdata | input | 32 | Data-port write data, little-endian |
| dp_rdata | output | 32 | Data-port read data |
| dp_rvalid | output | 1 | Read data valid |
| irq | output | 1 | Interrupt, enabled status present |

## Verification
The bench sweeps the stop boundary over several offsets from the start boundary in all three access sizes. Some of these runs hit the stop value exactly and some step over it. A design that used a greater-or-equal compare would fold the overshooting runs back to the start. A design with no wrap would run the address out of the ring.

Counts that are not multiples of the access size exercise the saturating decrement. A plain subtract would wrap the count to a large value, leave the completion bit clear, and keep accepting writes.

Writes issued after the count is exhausted are followed by register and RAM readback. A design that let them through would move the address or overwrite buffer bytes.

Unaligned word accesses that cross the top of the RAM check the little-endian byte placement. Status-clear and mask toggles check that the interrupt follows only enabled, uncleared status.

// File: rtl/rdma_pkg.sv
package rdma_pkg;
  localparam logic [2:0] SEL_START = 3'd0;
  localparam logic [2:0] SEL_STOP  = 3'd1;
  localparam logic [2:0] SEL_ADDR  = 3'd2;
  localparam logic [2:0] SEL_COUNT = 3'd3;
  localparam logic [2:0] SEL_CFG   = 3'd4;
  localparam logic [2:0] SEL_STAT  = 3'd5;
  localparam logic [2:0] SEL_MASK  = 3'd6;

  localparam int DONE_BIT = 0;

  typedef enum logic [1:0] {
    XS_BYTE = 2'd0,
    XS_HALF = 2'd1,
    XS_WORD = 2'd2
  } xfer_size_e;

  function automatic logic [2:0] size_bytes(input xfer_size_e s);
    case (s)
      XS_HALF: size_bytes = 3'd2;
      XS_WORD: size_bytes = 3'd4;
      default: size_bytes = 3'd1;
    endcase
  endfunction
endpackage

// File: rtl/rdma_step.sv
module rdma_step #(
  parameter int REG_W = 16
) (
  input  logic [REG_W-1:0] cur_addr,
  input  logic [REG_W-1:0] cur_cnt,
  input  logic [REG_W-1:0] ring_start,
  input  logic [REG_W-1:0] ring_stop,
  input  logic [2:0]       nbytes,
  output logic [REG_W-1:0] nxt_addr,
  output logic [REG_W-1:0] nxt_cnt,
  output logic             final_xfer
);
  logic [REG_W-1:0] step_w;
  logic [REG_W-1:0] sum;

  assign step_w     = REG_W'(nbytes);
  assign sum        = cur_addr + step_w;
  assign nxt_addr   = (sum == ring_stop) ? ring_start : sum;
  assign final_xfer = (cur_cnt <= step_w);
  assign nxt_cnt    = final_xfer ? '0 : (cur_cnt - step_w);
endmodule

// File: rtl/rdma_bank_ram.sv
module rdma_bank_ram #(
  parameter int RAM_AW = 14
) (
  input  logic              clk,
  input  logic              we,
  input  logic [RAM_AW-1:0] addr,
  input  logic [2:0]        nbytes,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata
);
  localparam int LANES = 4;
  localparam int ROW_W = RAM_AW - 2;
  localparam int ROWS  = 1 << ROW_W;

  logic [1:0]  off_q;
  logic [31:0] rd_all;

  always_ff @(posedge clk) begin
    off_q <= addr[1:0];
  end

  for (genvar b = 0; b < LANES; b++) begin : g_bank
    logic [7:0]        mem [ROWS];
    logic [7:0]        q;
    logic [1:0]        lane;
    logic [RAM_AW-1:0] baddr;
    logic              wr;

    assign lane  = 2'(b) - addr[1:0];
    assign baddr = addr + RAM_AW'(lane);
    assign wr    = we && ({1'b0, lane} < nbytes);

    always_ff @(posedge clk) begin
      if (wr) mem[baddr[RAM_AW-1:2]] <= wdata[{lane, 3'b000} +: 8];
      q <= mem[baddr[RAM_AW-1:2]];
    end

    assign rd_all[8*b +: 8] = q;
  end

  for (genvar k = 0; k < LANES; k++) begin : g_rot
    logic [1:0] src;
    assign src = off_q + 2'(k);
    assign rdata[8*k +: 8] = rd_all[{src, 3'b000} +: 8];
  end
endmodule

// File: rtl/rdma_ring_port.sv
module rdma_ring_port
  import rdma_pkg::*;
#(
  parameter int REG_W  = 16,
  parameter int RAM_AW = 14,
  parameter int ST_W   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_we,
  input  logic [2:0]       reg_sel,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             dp_req,
  input  logic             dp_we,
  input  logic             dp_wide,
  input  logic [31:0]      dp_wdata,
  output logic [31:0]      dp_rdata,
  output logic             dp_rvalid,
  output logic             irq
);
  logic [REG_W-1:0] start_q, stop_q, addr_q, cnt_q;
  logic             cfg_q;
  logic [ST_W-1:0]  status_q, mask_q;
  logic [ST_W-1:0]  status_d, mask_d;

  xfer_size_e       xs;
  logic [2:0]       nbytes;
  logic             acc;
  logic [REG_W-1:0] addr_nxt, cnt_nxt;
  logic             last;

  always_comb begin
    if (dp_wide)    xs = XS_WORD;
    else if (cfg_q) xs = XS_HALF;
    else            xs = XS_BYTE;
  end

  assign nbytes = size_bytes(xs);
  assign acc    = dp_req && (!dp_we || (cnt_q != '0));

  rdma_step #(.REG_W(REG_W)) u_step (
    .cur_addr   (addr_q),
    .cur_cnt    (cnt_q),
    .ring_start (start_q),
    .ring_stop  (stop_q),
    .nbytes     (nbytes),
    .nxt_addr   (addr_nxt),
    .nxt_cnt    (cnt_nxt),
    .final_xfer (last)
  );

  rdma_bank_ram #(.RAM_AW(RAM_AW)) u_ram (
    .clk    (clk),
    .we     (acc && dp_we),
    .addr   (addr_q[RAM_AW-1:0]),
    .nbytes (nbytes),
    .wdata  (dp_wdata),
    .rdata  (dp_rdata)
  );

  always_comb begin
    status_d = status_q;
    mask_d   = mask_q;
    if (reg_we && reg_sel == SEL_STAT) status_d = status_d & ~reg_wdata[ST_W-1:0];
    if (reg_we && reg_sel == SEL_MASK) mask_d = reg_wdata[ST_W-1:0];
    if (acc && last) status_d[DONE_BIT] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q   <= '0;
      stop_q    <= '0;
      addr_q    <= '0;
      cnt_q     <= '0;
      cfg_q     <= 1'b0;
      status_q  <= '0;
      mask_q    <= '0;
      irq       <= 1'b0;
      dp_rvalid <= 1'b0;
      reg_rdata <= '0;
    end else begin
      if (reg_we) begin
        case (reg_sel)
          SEL_START: start_q <= reg_wdata;
          SEL_STOP:  stop_q  <= reg_wdata;
          SEL_ADDR:  addr_q  <= reg_wdata;
          SEL_COUNT: cnt_q   <= reg_wdata;
          SEL_CFG:   cfg_q   <= reg_wdata[0];
          default: ;
        endcase
      end
      if (acc) begin
        addr_q <= addr_nxt;
        cnt_q  <= cnt_nxt;
      end
      status_q  <= status_d;
      mask_q    <= mask_d;
      irq       <= |(status_d & mask_d);
      dp_rvalid <= dp_req && !dp_we;
      case (reg_sel)
        SEL_START: reg_rdata <= start_q;
        SEL_STOP:  reg_rdata <= stop_q;
        SEL_ADDR:  reg_rdata <= addr_q;
        SEL_COUNT: reg_rdata <= cnt_q;
        SEL_CFG:   reg_rdata <= REG_W'(cfg_q);
        SEL_STAT:  reg_rdata <= REG_W'(status_q);
        SEL_MASK:  reg_rdata <= REG_W'(mask_q);
        default:   reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/rdma_ring_port_chk.sv
module rdma_ring_port_chk #(
  parameter int REG_W = 16,
  parameter int ST_W  = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             reg_we,
  input logic             dp_req,
  input logic             dp_we,
  input logic             dp_rvalid,
  input logic             irq,
  input logic             acc,
  input logic [2:0]       nbytes,
  input logic [REG_W-1:0] addr_q,
  input logic [REG_W-1:0] cnt_q,
  input logic [REG_W-1:0] start_q,
  input logic [REG_W-1:0] stop_q,
  input logic [ST_W-1:0]  status_q,
  input logic [ST_W-1:0]  mask_q
);
  logic [REG_W-1:0] adv;
  assign adv = addr_q + REG_W'(nbytes);

  p_step_r1: assert property (@(posedge clk) disable iff (rst)
    acc && (adv != stop_q) |=> addr_q == $past(adv));

  p_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    acc && (adv == stop_q) |=> addr_q == $past(start_q));

  p_sat_r4: assert property (@(posedge clk) disable iff (rst)
    acc && (cnt_q <= REG_W'(nbytes)) |=> cnt_q == '0);

  p_dec_r4: assert property (@(posedge clk) disable iff (rst)
    acc && (cnt_q > REG_W'(nbytes)) && !reg_we |=> cnt_q == $past(cnt_q) - REG_W'($past(nbytes)));

  p_done_r5: assert property (@(posedge clk) disable iff (rst)
    acc && (cnt_q <= REG_W'(nbytes)) |=> status_q[0]);

  p_irq_r6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |-> irq == |(status_q & mask_q));

  p_ignore_r7: assert property (@(posedge clk) disable iff (rst)
    dp_req && dp_we && (cnt_q == '0) && !reg_we |=> $stable(addr_q) && (cnt_q == '0) && $stable(status_q));

  p_rvalid_r8: assert property (@(posedge clk) disable iff (rst)
    dp_req && !dp_we |=> dp_rvalid);
endmodule

bind rdma_ring_port rdma_ring_port_chk #(.REG_W(REG_W), .ST_W(ST_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_we    (reg_we),
  .dp_req    (dp_req),
  .dp_we     (dp_we),
  .dp_rvalid (dp_rvalid),
  .irq       (irq),
  .acc       (acc),
  .nbytes    (nbytes),
  .addr_q    (addr_q),
  .cnt_q     (cnt_q),
  .start_q   (start_q),
  .stop_q    (stop_q),
  .status_q  (status_q),
  .mask_q    (mask_q)
);

// File: tb/tb_rdma_ring_port.sv
`timescale 1ns/1ps
module tb_rdma_ring_port;
  logic        clk = 1'b0;
  logic        rst;
  logic        reg_we;
  logic [2:0]  reg_sel;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic        dp_req, dp_we, dp_wide;
  logic [31:0] dp_wdata;
  logic [31:0] dp_rdata;
  logic        dp_rvalid;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [7:0] mem_m [16384];
  int m_start, m_stop, m_addr, m_cnt, m_cfg, m_stat, m_mask;

  always #4 clk = ~clk;

  rdma_ring_port dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .dp_req(dp_req), .dp_we(dp_we), .dp_wide(dp_wide),
    .dp_wdata(dp_wdata), .dp_rdata(dp_rdata), .dp_rvalid(dp_rvalid), .irq(irq)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] sel, input int val);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = 16'(val);
    @(negedge clk);
    reg_we = 1'b0;
    case (sel)
      3'd0: m_start = val & 16'hFFFF;
      3'd1: m_stop  = val & 16'hFFFF;
      3'd2: m_addr  = val & 16'hFFFF;
      3'd3: m_cnt   = val & 16'hFFFF;
      3'd4: m_cfg   = val & 1;
      3'd5: m_stat  = m_stat & ~(val & 8'hFF);
      3'd6: m_mask  = val & 8'hFF;
      default: ;
    endcase
  endtask

  task automatic reg_read(input logic [2:0] sel, output logic [15:0] v);
    @(negedge clk);
    reg_sel = sel;
    @(negedge clk);
    v = reg_rdata;
  endtask

  task automatic check_state(input string req);
    logic [15:0] v;
    reg_read(3'd2, v); chk(req, "address", 32'(v), 32'(m_addr));
    reg_read(3'd3, v); chk(req, "count", 32'(v), 32'(m_cnt));
    reg_read(3'd5, v); chk(req, "status", 32'(v), 32'(m_stat));
    chk("R6", "irq", 32'(irq), 32'((m_stat & m_mask) != 0));
  endtask

  task automatic dp_op(input bit we, input bit wide, input logic [31:0] wd);
    int sz;
    logic [31:0] exp_rd;
    sz = wide ? 4 : (m_cfg ? 2 : 1);
    exp_rd = '0;
    for (int k = 0; k < sz; k++) exp_rd[8*k +: 8] = mem_m[(m_addr + k) & 16'h3FFF];
    @(negedge clk);
    dp_req = 1'b1; dp_we = we; dp_wide = wide; dp_wdata = wd;
    @(negedge clk);
    dp_req = 1'b0; dp_we = 1'b0;
    if (!we) begin
      chk("R8", "rvalid", 32'(dp_rvalid), 32'd1);
      for (int k = 0; k < sz; k++)
        chk("R9", "read byte", 32'(dp_rdata[8*k +: 8]), 32'(exp_rd[8*k +: 8]));
    end
    if (!(we && m_cnt == 0)) begin
      if (we) for (int k = 0; k < sz; k++) mem_m[(m_addr + k) & 16'h3FFF] = wd[8*k +: 8];
      m_addr = (m_addr + sz) & 16'hFFFF;
      if (m_addr == m_stop) m_addr = m_start;
      if (m_cnt <= sz) begin m_cnt = 0; m_stat = m_stat | 1; end
      else m_cnt = m_cnt - sz;
    end
  endtask

  task automatic ring_setup(input int s, input int e, input int a, input int c, input int cfg);
    reg_write(3'd0, s); reg_write(3'd1, e); reg_write(3'd2, a);
    reg_write(3'd3, c); reg_write(3'd4, cfg);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog all actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    rst = 1'b1; reg_we = 0; reg_sel = 0; reg_wdata = 0;
    dp_req = 0; dp_we = 0; dp_wide = 0; dp_wdata = 0;
    m_start = 0; m_stop = 0; m_addr = 0; m_cnt = 0; m_cfg = 0; m_stat = 0; m_mask = 0;
    for (int i = 0; i < 16384; i++) mem_m[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R10: reset values
    for (int s = 0; s < 7; s++) begin
      reg_read(3'(s), v);
      chk("R10", "reset register", 32'(v), 32'd0);
    end
    chk("R10", "reset irq", 32'(irq), 32'd0);

    // Pre-fill the region later read back, so the RAM model is defined
    ring_setup(16'h0000, 16'hFFFF, 16'h0000, 16'h0800, 0);
    for (int i = 0; i < 2048; i++) dp_op(1'b1, 1'b0, 32'(i * 7 + 3));
    reg_write(3'd5, 1);
    ring_setup(16'h3F00, 16'hFFFF, 16'h3F00, 16'h0100, 0);
    for (int i = 0; i < 256; i++) dp_op(1'b1, 1'b0, 32'(i ^ 8'h5A));
    reg_write(3'd5, 1);

    // R1 R2 R4 R5 R6: byte mode ring with mask enabled
    reg_write(3'd6, 1);
    ring_setup(16'h0040, 16'h0048, 16'h0044, 11, 0);
    for (int i = 0; i < 11; i++) begin
      dp_op(1'b1, 1'b0, 32'(8'hA0 + i));
      check_state("R2");
    end
    // R7: write after count exhausted is dropped
    dp_op(1'b1, 1'b0, 32'hEE);
    check_state("R7");
    reg_write(3'd5, 1);
    check_state("R5");
    ring_setup(16'h0040, 16'h0048, 16'h0040, 8, 0);
    for (int i = 0; i < 8; i++) dp_op(1'b0, 1'b0, '0);
    check_state("R8");

    // R4: halfword mode with odd count
    reg_write(3'd5, 1);
    ring_setup(16'h0100, 16'h010C, 16'h0100, 7, 1);
    for (int i = 0; i < 4; i++) begin
      dp_op(1'b1, 1'b0, 32'(16'hB000 + i * 16'h0111));
      check_state("R4");
    end
    ring_setup(16'h0100, 16'h010C, 16'h0100, 8, 1);
    for (int i = 0; i < 4; i++) dp_op(1'b0, 1'b0, '0);

    // R3: halfword steps over an odd stop value without wrapping
    reg_write(3'd5, 1);
    ring_setup(16'h0200, 16'h0205, 16'h0200, 8, 1);
    for (int i = 0; i < 4; i++) begin
      dp_op(1'b1, 1'b0, 32'(16'hC100 + i));
      check_state("R3");
    end

    // R9: unaligned word accesses, including across the top of the RAM
    reg_write(3'd5, 1);
    ring_setup(16'h0300, 16'h0000, 16'h3FFE, 12, 0);
    dp_op(1'b1, 1'b1, 32'h11223344);
    dp_op(1'b1, 1'b1, 32'h55667788);
    dp_op(1'b1, 1'b1, 32'h99AABBCC);
    check_state("R9");
    ring_setup(16'h0300, 16'h0000, 16'h3FFD, 16, 0);
    for (int i = 0; i < 4; i++) dp_op(1'b0, 1'b1, '0);
    check_state("R9");

    // R1 R2 R3: sweep of stop offsets in all three sizes
    for (int m = 0; m < 3; m++) begin
      for (int so = 1; so < 8; so++) begin
        reg_write(3'd5, 1);
        ring_setup(16'h0600, 16'h0600 + so, 16'h0600, 9, (m == 1) ? 1 : 0);
        for (int i = 0; i < 5; i++) begin
          dp_op(1'b1, m == 2, 32'(32'h0A0B0C00 + so * 16 + i));
          check_state("R1");
        end
      end
    end

    // R5 R6: mask gating and write-one-to-clear
    reg_write(3'd6, 0);
    ring_setup(16'h0700, 16'h0710, 16'h0700, 1, 0);
    dp_op(1'b0, 1'b0, '0);
    check_state("R6");
    reg_write(3'd6, 1);
    check_state("R6");
    reg_write(3'd5, 0);
    check_state("R5");
    reg_write(3'd5, 1);
    check_state("R5");

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule